// File: doc/BRIEF.md
# Multicart Bank Latch with PRG Modes

This block is the address-mapping controller of a cartridge for an 8-bit console that holds many games in one ROM. It watches CPU write cycles in the upper ROM window. When a write qualifies, it stores part of the CPU address and the whole data byte in one configuration latch. The latch then defines the game that is selected.

The latched value and the current CPU address feed combinational logic. That logic drives the upper PRG ROM address lines A21..A13 and a ROM select for the $6000-$7FFF window. It also drives the nametable mirroring line and a gated CHR-RAM write enable.

The static parameter `SUBMAPPER` selects the board variant. It sets the address window that loads the latch and decides whether PRG A21 comes from the latch or is tied high. All pins are plain control signals with no handshake. A write is taken on the rising clock edge where the strobe is sampled high.

Top module: `multicart_bank_mapper`

## Requirements
- R1: With SUBMAPPER=1, a qualifying write to any address in $E000-$FFFF loads the latch. With SUBMAPPER=0, only writes in $F000-$FFFF load it.
- R2: The latch stays unchanged in each of these cases: a strobe outside the decode window, a strobe with cpu_rw high (read), or a strobe with romsel_n high. This covers writes to $8000-$DFFF on SUBMAPPER=1 and writes to $8000-$EFFF on SUBMAPPER=0.
- R3: On reset, every latch bit clears. At CPU address $8000 the result is mode 0, bank 0, mirror_h=0, chr_we following ppu_we, and prg_hi=0 on SUBMAPPER=1.
- R4: The latched address fields are as follows. A[2:0] is the PRG mode, A[3]=1 write-protects CHR-RAM, A[4] drives PRG A20, and A[12] drives PRG A21 on SUBMAPPER=1.
- R5: The latched data fields are as follows. D[5:0] drives PRG A19..A14, D[6] drives mirror_h (0 vertical, 1 horizontal), and D[7] is the bit p. Output prg_hi[8:0] is PRG A21..A13, with bit 0 = A13.
- R6: In modes 0 and 4, PRG A14 follows CPU A14 instead of latched D[0].
- R7: In mode 1, PRG A16..A14 read 111 while CPU A14=1. While CPU A14=0, they come from the latch.
- R8: In modes 2 and 6, PRG A13 equals p. In modes 3 and 7, the 16 KiB bank from the latch appears at both $8000 and $C000.
- R9: In mode 5, the following holds:
  - At $6000-$7FFF, PRG A19..A14 come from the latch, PRG A13=p, and prg_lo_sel=1.
  - At $8000-$FFFF, PRG A14=CPU A14 and PRG A16..A15=11.
  - In every other mode, and at every other address, prg_lo_sel=0.
- R10: With SUBMAPPER=0, PRG A21 is driven high at all times.
- R11: chr_we equals ppu_we while the write-protect bit is clear, and is 0 while it is set.
- R12: In modes 0, 1, 3, 4 and 7, PRG A13 follows CPU A13, and p has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Active-low reset, clears the latch |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| romsel_n | input | 1 | Active-low ROM window select |
| wr_stb | input | 1 | Bus cycle strobe, sampled at the rising edge |
| ppu_we | input | 1 | PPU write request toward CHR-RAM |
| prg_hi | output | 9 | PRG ROM address A21..A13 |
| prg_lo_sel | output | 1 | ROM select for $6000-$7FFF |
| mirror_h | output | 1 | Nametable mirroring, 1 = horizontal |
| chr_we | output | 1 | Gated CHR-RAM write enable |

## Verification
Each of the eight modes is loaded with a bank pattern whose bits can be told apart. The routed address is then read at addresses that differ only in CPU A14 or A13. This shows whether a line comes from the latch, from the CPU, or is forced high.

Setting p opposite to CPU A13 separates modes 2, 6 and 5 from the modes that ignore p. Mode 5 is also read at $6000 and at $8000-$FFFF, which exposes a mix-up between its two halves.

Two instances with different SUBMAPPER values receive the same $E000-page write. This checks the decode window and the A21 tie-off. Further tests cover reads, inactive ROM select, low addresses and a mid-run reset, and each must leave the latch untouched or cleared.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BANK_W = 6;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned HI_W   = BANK_W + 3;  // A21, A20, bank, A13

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              wp;
    logic              a20;
    logic              a21;
    logic [BANK_W-1:0] bank;   // bank[0] = PRG A14
    logic              mirror;
    logic              p;
  } cfg_t;

  localparam cfg_t CFG_RESET = '0;
endpackage

// File: rtl/mcm_cfg_latch.sv
module mcm_cfg_latch
  import mcm_pkg::*;
#(
  parameter int unsigned SUBMAPPER = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_rw,
  input  logic              romsel_n,
  input  logic              wr_stb,
  output cfg_t              cfg
);
  logic win_hit;
  logic take;
  cfg_t nxt;

  generate
    if (SUBMAPPER == 0) begin : g_dec_f
      assign win_hit = (cpu_addr[15:12] == 4'hF);
    end else begin : g_dec_ef
      assign win_hit = (cpu_addr[15:13] == 3'b111);
    end
  endgenerate

  assign take = wr_stb && !cpu_rw && !romsel_n && win_hit;

  always_comb begin
    nxt.mode   = cpu_addr[MODE_W-1:0];
    nxt.wp     = cpu_addr[3];
    nxt.a20    = cpu_addr[4];
    nxt.a21    = (SUBMAPPER == 0) ? 1'b0 : cpu_addr[12];
    nxt.bank   = cpu_data[BANK_W-1:0];
    nxt.mirror = cpu_data[6];
    nxt.p      = cpu_data[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg <= CFG_RESET;
    else if (take) cfg <= nxt;
  end

  AST_LOAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cfg.mode == $past(cpu_addr[2:0]))); // R1
  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cfg.bank == $past(cpu_data[5:0]) && cfg.p == $past(cpu_data[7]))); // R5
  AST_IGNORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (cpu_rw || romsel_n || !win_hit)) |=> $stable(cfg)); // R2
endmodule

// File: rtl/mcm_prg_route.sv
module mcm_prg_route
  import mcm_pkg::*;
#(
  parameter int unsigned SUBMAPPER = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [HI_W-1:0]   prg_hi,
  output logic              prg_lo_sel
);
  logic [BANK_W-1:0] bank_o;
  logic              a13_o;
  logic              lo_win;
  logic              a21_o;

  assign lo_win = (cpu_addr[15:13] == 3'b011);

  generate
    if (SUBMAPPER == 0) begin : g_a21_tie
      assign a21_o = 1'b1;
    end else begin : g_a21_latch
      assign a21_o = cfg.a21;
    end
  endgenerate

  always_comb begin
    bank_o     = cfg.bank;
    a13_o      = cpu_addr[13];
    prg_lo_sel = 1'b0;
    case (cfg.mode)
      3'd0, 3'd4: bank_o[0] = cpu_addr[14];
      3'd1: if (cpu_addr[14]) bank_o[2:0] = 3'b111;
      3'd2, 3'd6: a13_o = cfg.p;
      3'd5: begin
        if (!cpu_addr[15]) begin
          a13_o      = cfg.p;
          prg_lo_sel = lo_win;
        end else begin
          bank_o[0]   = cpu_addr[14];
          bank_o[2:1] = 2'b11;
        end
      end
      default: ;
    endcase
  end

  assign prg_hi = {a21_o, cfg.a20, bank_o, a13_o};

  AST_UNROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == 3'd1 && cpu_addr[14]) |-> (prg_hi[3:1] == 3'b111)); // R7
  AST_LO_SEL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    prg_lo_sel |-> (cfg.mode == 3'd5 && cpu_addr[15:13] == 3'b011)); // R9
  AST_NROM256_A14: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode[1:0] == 2'b00) |-> (prg_hi[1] == cpu_addr[14])); // R6
  AST_SUB0_A21: assert property (@(posedge clk) disable iff (!rst_n)
    (SUBMAPPER == 0) |-> prg_hi[HI_W-1]); // R10
endmodule

// File: rtl/mcm_ppu_side.sv
module mcm_ppu_side
  import mcm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic ppu_we,
  output logic mirror_h,
  output logic chr_we
);
  assign mirror_h = cfg.mirror;
  assign chr_we   = ppu_we & ~cfg.wp;

  AST_CHR_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.wp |-> !chr_we); // R11
endmodule

// File: rtl/multicart_bank_mapper.sv
module multicart_bank_mapper
  import mcm_pkg::*;
#(
  parameter int unsigned SUBMAPPER = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_rw,
  input  logic              romsel_n,
  input  logic              wr_stb,
  input  logic              ppu_we,
  output logic [HI_W-1:0]   prg_hi,
  output logic              prg_lo_sel,
  output logic              mirror_h,
  output logic              chr_we
);
  cfg_t cfg;

  mcm_cfg_latch #(.SUBMAPPER(SUBMAPPER)) u_latch (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .romsel_n(romsel_n), .wr_stb(wr_stb), .cfg(cfg)
  );

  mcm_prg_route #(.SUBMAPPER(SUBMAPPER)) u_route (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cpu_addr(cpu_addr),
    .prg_hi(prg_hi), .prg_lo_sel(prg_lo_sel)
  );

  mcm_ppu_side u_ppu (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .ppu_we(ppu_we),
    .mirror_h(mirror_h), .chr_we(chr_we)
  );
endmodule

// File: tb/tb_multicart_bank_mapper.sv
`timescale 1ns/1ps
module tb_multicart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_rw = 1'b1;
  logic        romsel_n = 1'b1;
  logic        wr_stb = 1'b0;
  logic        ppu_we = 1'b0;
  logic [8:0]  hi1, hi0;
  logic        lo1, lo0, mir1, mir0, cwe1, cwe0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  multicart_bank_mapper #(.SUBMAPPER(1)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .romsel_n(romsel_n), .wr_stb(wr_stb), .ppu_we(ppu_we),
    .prg_hi(hi1), .prg_lo_sel(lo1), .mirror_h(mir1), .chr_we(cwe1)
  );

  multicart_bank_mapper #(.SUBMAPPER(0)) dut_s0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .romsel_n(romsel_n), .wr_stb(wr_stb), .ppu_we(ppu_we),
    .prg_hi(hi0), .prg_lo_sel(lo0), .mirror_h(mir0), .chr_we(cwe0)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rw, input logic rs_n);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = rw; romsel_n = rs_n; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cpu_rw = 1'b1; romsel_n = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus(a, d, 1'b0, 1'b0);
  endtask

  task automatic look(input logic [15:0] a);
    cpu_addr = a;
    #1;
  endtask

  task automatic t_reset();
    look(16'h8000); ppu_we = 1'b1; #1;
    chk("R3", "hi sub1", hi1, 9'h000);
    chk("R10", "hi sub0 A21", hi0, 9'h100);
    chk("R3", "mirror", mir1, 0);
    chk("R3", "chr_we", cwe1, 1);
    chk("R3", "lo_sel", lo1, 0);
  endtask

  task automatic t_fields();
    wr(16'hE01B, 8'hC5);  // mode 3, wp, A20, bank 5, mirror, p
    look(16'hA000);
    chk("R4", "hi fields", hi1, 9'h08B);
    chk("R5", "mirror", mir1, 1);
    chk("R11", "chr_we protected", cwe1, 0);
  endtask

  task automatic t_mode0_4();
    wr(16'hF000, 8'h07);
    look(16'hC000); chk("R6", "m0 C000", hi1, 9'h10E);
    look(16'h8000); chk("R6", "m0 8000", hi1, 9'h10C);
    chk("R11", "chr_we open", cwe1, 1);
    chk("R5", "mirror v", mir1, 0);
    look(16'h6000); chk("R9", "lo_sel m0", lo1, 0);
    wr(16'hF004, 8'h87);
    look(16'hC000); chk("R6", "m4 C000", hi1, 9'h10E);
    look(16'hA000); chk("R12", "m4 A13 from cpu", hi1, 9'h10D);
  endtask

  task automatic t_mode1();
    wr(16'hE001, 8'h2A);
    look(16'h8000); chk("R7", "m1 low half", hi1, 9'h054);
    look(16'hE000); chk("R7", "m1 high half", hi1, 9'h05F);
  endtask

  task automatic t_mode2_6_3_7();
    wr(16'hE002, 8'h81);
    look(16'h8000); chk("R8", "m2 8000", hi1, 9'h003);
    look(16'hC000); chk("R8", "m2 C000", hi1, 9'h003);
    wr(16'hE006, 8'h01);
    look(16'hA000); chk("R8", "m6 A13=p", hi1, 9'h002);
    wr(16'hE007, 8'h83);
    look(16'hE000); chk("R12", "m7 E000", hi1, 9'h007);
    look(16'hC000); chk("R8", "m7 C000", hi1, 9'h006);
    look(16'h8000); chk("R8", "m7 8000 mirror", hi1, 9'h006);
  endtask

  task automatic t_mode5();
    wr(16'hE005, 8'h89);
    look(16'h6000);
    chk("R9", "m5 6000 hi", hi1, 9'h013);
    chk("R9", "m5 6000 sel", lo1, 1);
    look(16'h8000);
    chk("R9", "m5 8000 hi", hi1, 9'h01C);
    chk("R9", "m5 8000 sel", lo1, 0);
    look(16'hE000); chk("R9", "m5 E000", hi1, 9'h01F);
  endtask

  task automatic t_ignored();
    wr(16'hD005, 8'hFF);
    bus(16'hE000, 8'hFF, 1'b1, 1'b0);
    bus(16'hE000, 8'hFF, 1'b0, 1'b1);
    look(16'h6000);
    chk("R2", "ignored writes hi", hi1, 9'h013);
    chk("R2", "ignored writes sel", lo1, 1);
  endtask

  task automatic t_sub0();
    rst_n = 1'b0; #3; rst_n = 1'b1;
    look(16'h8000); chk("R3", "mid-run reset", hi1, 9'h000);
    wr(16'hE003, 8'h3F);
    look(16'h8000);
    chk("R2", "sub0 E000 ignored", hi0, 9'h100);
    chk("R1", "sub1 E000 taken", hi1, 9'h07E);
    wr(16'hF003, 8'h3F);
    look(16'h8000); chk("R1", "sub0 F000 taken", hi0, 9'h17E);
    chk("R10", "sub0 A21 high", hi0[8], 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_mode0_4();
    t_mode1();
    t_mode2_6_3_7();
    t_mode5();
    t_ignored();
    t_sub0();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule